// File: doc/BRIEF.md
# Invalidate Forwarding Queue

This block sits beside a single-processor cache level that keeps no coherence state of its own and is not the outermost level facing the processor. When the bus below shows a command that kills a line, the block keeps a copy of it as an invalidate entry (command, line address, transfer size). It then hands those entries upward so that the caches above drop their copies. Entries leave through a valid/ready stream in arrival order. While anything is waiting, a request flag tells the cache that forwarding work is pending. While storage is full, a blocked signal tells the snoop side to hold off.

The same block gives the cache its simple answers for this level. A snooped line is never supplied with data. A killed line goes to the all-zero state, and any other hit keeps its status. Every miss goes out as a plain read, except writebacks, which keep their command. A filled line is marked valid and writable, and also carries a prefetch mark when the fill came from a hardware prefetch. A hardware prefetch that finds its line already present raises a warning pulse.

Command code (3 bits): 0 read, 1 read-exclusive, 2 upgrade, 3 invalidate, 4 write-invalidate, 5 writeback, 6 hardware prefetch, 7 write. Status bits: bit 0 valid, bit 1 writable, bit 2 dirty, bit 3 prefetched.

Top module: `inv_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `fwd_valid`, `coh_req` and `snoop_blocked` are all 0.
- R2: A snoop with `snoop_valid` high, `top_level` low and a command code of 1, 2, 3 or 4 stores one entry holding command code 3, the snoop address and the snoop size. Codes 0, 5, 6 and 7 store nothing. `snoop_hit` does not affect storage.
- R3: While `top_level` is high, no snooped command stores an entry.
- R4: Entries leave in arrival order, one per cycle in which `fwd_valid` and `fwd_ready` are both high. The queue holds up to DEPTH entries (default 50). When `fwd_ready` is high and `fwd_valid` is low, nothing changes.
- R5: `coh_req` rises in the cycle after a store. It falls in the cycle after the transfer that takes out the last entry.
- R6: `snoop_blocked` rises in the cycle after the store that fills the queue. It falls in the cycle after a transfer out of a full queue. An invalidating snoop that arrives while the queue is full is dropped.
- R7: A store and a transfer out in the same cycle both take effect, and the occupancy does not change.
- R8: `snoop_new_state` is 0 when the snoop misses or carries an invalidating code (1 to 4). On a hit with any other code it equals `blk_status`. `snoop_supply` is always 0.
- R9: `bus_cmd` is 5 when `req_cmd` is 5, and 0 for every other code.
- R10: `fill_state` is 4'b0011. It is 4'b1011 when `fill_orig_cmd` is 6.
- R11: `pf_hit_warn` is high exactly when `req_valid` is high, `req_cmd` is 6 and `req_hit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_level | input | 1 | High when this cache is the outermost level; disables forwarding |
| snoop_valid | input | 1 | A snooped bus command is present this cycle |
| snoop_cmd | input | 3 | Snooped command code |
| snoop_addr | input | AW (32) | Snooped line address |
| snoop_size | input | SW (8) | Snooped transfer size |
| snoop_hit | input | 1 | The snooped line is present in this cache |
| blk_status | input | 4 | Current status bits of the snooped line |
| snoop_new_state | output | 4 | Status the line takes after the snoop |
| snoop_supply | output | 1 | This cache supplies data (always 0) |
| snoop_blocked | output | 1 | Queue full; the snoop side must hold off |
| coh_req | output | 1 | Forwarding work is pending |
| fwd_valid | output | 1 | Head entry is available |
| fwd_ready | input | 1 | Consumer takes the head entry |
| fwd_cmd | output | 3 | Head entry command (invalidate, code 3) |
| fwd_addr | output | AW (32) | Head entry address |
| fwd_size | output | SW (8) | Head entry size |
| req_valid | input | 1 | A processor-side request is present |
| req_cmd | input | 3 | Processor-side request command |
| req_hit | input | 1 | The request's line is already present |
| bus_cmd | output | 3 | Command to send down on a miss |
| fill_orig_cmd | input | 3 | Command of the request whose fill is arriving |
| fill_state | output | 4 | Status bits to write on fill |
| pf_hit_warn | output | 1 | A hardware prefetch found its line present |

## Verification
The bench fills all 50 entries and checks that the blocked signal comes up on the 50th store and not the 49th. A design with an off-by-one full test would block early or would overwrite the oldest entry. It then offers a snoop while full and drains the queue. A design that accepted the extra snoop would return an address that was never meant to be stored, or would return the entries in the wrong order. A store and a transfer in the same cycle next to the full mark must leave the queue one short of full; a design that let one of the two win would block or lose an entry. The bench also sweeps every command, hit and top-level combination, which catches a wrong invalidating set or a forwarding path that ignores the top-level setting.

// File: rtl/inv_fwd_pkg.sv
package inv_fwd_pkg;
  localparam int CMD_W = 3;
  localparam int ST_W  = 4;

  localparam logic [CMD_W-1:0] C_READ     = 3'd0;
  localparam logic [CMD_W-1:0] C_READ_EX  = 3'd1;
  localparam logic [CMD_W-1:0] C_UPGRADE  = 3'd2;
  localparam logic [CMD_W-1:0] C_INVAL    = 3'd3;
  localparam logic [CMD_W-1:0] C_WR_INVAL = 3'd4;
  localparam logic [CMD_W-1:0] C_WRBACK   = 3'd5;
  localparam logic [CMD_W-1:0] C_HW_PF    = 3'd6;
  localparam logic [CMD_W-1:0] C_WRITE    = 3'd7;

  localparam int S_VALID = 0;
  localparam int S_WRITE = 1;
  localparam int S_DIRTY = 2;
  localparam int S_PFMRK = 3;

  function automatic logic kills_line(input logic [CMD_W-1:0] c);
    return (c == C_READ_EX) || (c == C_UPGRADE) ||
           (c == C_INVAL)   || (c == C_WR_INVAL);
  endfunction
endpackage

// File: rtl/inv_fwd_fifo.sv
module inv_fwd_fifo #(
  parameter int DEPTH = 50,
  parameter int DW    = 43,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop  && (cnt_q != '0);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wr_ptr == PW'(gi))) store[gi] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_data = store[rd_ptr];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign count     = cnt_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_pop_drops_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_both_keep_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && do_push) |=> $stable(cnt_q));
endmodule

// File: rtl/inv_fwd_snoop_resp.sv
module inv_fwd_snoop_resp
  import inv_fwd_pkg::*;
(
  input  logic [CMD_W-1:0] snoop_cmd,
  input  logic             snoop_hit,
  input  logic [ST_W-1:0]  blk_status,
  output logic             is_kill,
  output logic [ST_W-1:0]  new_state,
  output logic             supply
);
  always_comb begin
    is_kill = kills_line(snoop_cmd);
    if (snoop_hit && !is_kill) new_state = blk_status;
    else                       new_state = '0;
    supply = 1'b0;
  end
endmodule

// File: rtl/inv_fwd_fill_ctl.sv
module inv_fwd_fill_ctl
  import inv_fwd_pkg::*;
(
  input  logic             req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic             req_hit,
  input  logic [CMD_W-1:0] fill_orig_cmd,
  output logic [CMD_W-1:0] bus_cmd,
  output logic [ST_W-1:0]  fill_state,
  output logic             pf_hit_warn
);
  always_comb begin
    bus_cmd = (req_cmd == C_WRBACK) ? C_WRBACK : C_READ;
    fill_state = '0;
    fill_state[S_VALID] = 1'b1;
    fill_state[S_WRITE] = 1'b1;
    fill_state[S_PFMRK] = (fill_orig_cmd == C_HW_PF);
    pf_hit_warn = req_valid && req_hit && (req_cmd == C_HW_PF);
  end
endmodule

// File: rtl/inv_fwd_queue.sv
module inv_fwd_queue
  import inv_fwd_pkg::*;
#(
  parameter int DEPTH = 50,
  parameter int AW    = 32,
  parameter int SW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             top_level,
  input  logic             snoop_valid,
  input  logic [2:0]       snoop_cmd,
  input  logic [AW-1:0]    snoop_addr,
  input  logic [SW-1:0]    snoop_size,
  input  logic             snoop_hit,
  input  logic [3:0]       blk_status,
  output logic [3:0]       snoop_new_state,
  output logic             snoop_supply,
  output logic             snoop_blocked,
  output logic             coh_req,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [2:0]       fwd_cmd,
  output logic [AW-1:0]    fwd_addr,
  output logic [SW-1:0]    fwd_size,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  input  logic             req_hit,
  output logic [2:0]       bus_cmd,
  input  logic [2:0]       fill_orig_cmd,
  output logic [3:0]       fill_state,
  output logic             pf_hit_warn
);
  localparam int DW = CMD_W + AW + SW;
  localparam int CW = $clog2(DEPTH + 1);

  logic          is_kill, q_empty, q_full, alloc, take;
  logic [CW-1:0] q_count;
  logic [DW-1:0] push_word, head_word;
  logic          blocked_q, req_q;

  inv_fwd_snoop_resp u_snoop (
    .snoop_cmd (snoop_cmd),
    .snoop_hit (snoop_hit),
    .blk_status(blk_status),
    .is_kill   (is_kill),
    .new_state (snoop_new_state),
    .supply    (snoop_supply)
  );

  inv_fwd_fill_ctl u_fill (
    .req_valid    (req_valid),
    .req_cmd      (req_cmd),
    .req_hit      (req_hit),
    .fill_orig_cmd(fill_orig_cmd),
    .bus_cmd      (bus_cmd),
    .fill_state   (fill_state),
    .pf_hit_warn  (pf_hit_warn)
  );

  assign alloc     = snoop_valid && is_kill && !top_level && !q_full;
  assign take      = fwd_ready && !q_empty;
  assign push_word = {C_INVAL, snoop_addr, snoop_size};

  inv_fwd_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (alloc),
    .push_data(push_word),
    .pop      (take),
    .head_data(head_word),
    .empty    (q_empty),
    .full     (q_full),
    .count    (q_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      if (alloc)                                  req_q <= 1'b1;
      else if (take && (q_count == CW'(1)))       req_q <= 1'b0;
      if (alloc && !take && (q_count == CW'(DEPTH - 1))) blocked_q <= 1'b1;
      else if (take && blocked_q)                 blocked_q <= 1'b0;
    end
  end

  assign coh_req       = req_q;
  assign snoop_blocked = blocked_q;
  assign fwd_valid     = !q_empty;
  assign {fwd_cmd, fwd_addr, fwd_size} = head_word;

  assert_req_tracks_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coh_req == !q_empty);
  assert_block_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_blocked == q_full);
  assert_top_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    top_level |=> (q_count <= $past(q_count)));
  assert_fwd_is_inval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_cmd == C_INVAL));
endmodule

// File: tb/inv_fwd_queue_tb.sv
module inv_fwd_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 50;

  logic clk = 0, rst_n = 0, top_level = 0;
  logic snoop_valid = 0, snoop_hit = 0, fwd_ready = 0;
  logic [2:0] snoop_cmd = 0, req_cmd = 0, fill_orig_cmd = 0;
  logic [31:0] snoop_addr = 0;
  logic [7:0] snoop_size = 0;
  logic [3:0] blk_status = 0;
  logic req_valid = 0, req_hit = 0;
  logic [3:0] snoop_new_state, fill_state;
  logic snoop_supply, snoop_blocked, coh_req, fwd_valid, pf_hit_warn;
  logic [2:0] fwd_cmd, bus_cmd;
  logic [31:0] fwd_addr;
  logic [7:0] fwd_size;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [39:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_fwd_queue u_dut (
    .clk(clk), .rst_n(rst_n), .top_level(top_level),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_size(snoop_size), .snoop_hit(snoop_hit), .blk_status(blk_status),
    .snoop_new_state(snoop_new_state), .snoop_supply(snoop_supply),
    .snoop_blocked(snoop_blocked), .coh_req(coh_req), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr),
    .fwd_size(fwd_size), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_hit(req_hit), .bus_cmd(bus_cmd), .fill_orig_cmd(fill_orig_cmd),
    .fill_state(fill_state), .pf_hit_warn(pf_hit_warn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic kills(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  // one snoop cycle; model updated per requirements R2, R3, R6
  task automatic snoop(input logic [2:0] c, input logic [31:0] a, input logic [7:0] s);
    snoop_valid = 1; snoop_cmd = c; snoop_addr = a; snoop_size = s;
    if (kills(c) && !top_level && model.size() < DEPTH) model.push_back({a, s});
    tick();
    snoop_valid = 0;
  endtask

  // take head, comparing against model (R4)
  task automatic take_one();
    logic [39:0] e;
    e = model.pop_front();
    chk("R4 valid", 32'(fwd_valid), 1);
    chk("R4 addr", fwd_addr, e[39:8]);
    chk("R4 size", 32'(fwd_size), 32'(e[7:0]));
    chk("R2 cmd", 32'(fwd_cmd), 3);
    fwd_ready = 1;
    tick();
    fwd_ready = 0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fwd_valid", 32'(fwd_valid), 0);
    chk("R1 coh_req", 32'(coh_req), 0);
    chk("R1 blocked", 32'(snoop_blocked), 0);

    // R8 sweep: snoop response, no snoop_valid so nothing stored
    for (int c = 0; c < 8; c++)
      for (int h = 0; h < 2; h++)
        for (int st = 0; st < 16; st++) begin
          snoop_cmd = 3'(c); snoop_hit = h[0]; blk_status = 4'(st);
          #1;
          chk("R8 new_state", 32'(snoop_new_state),
              (h == 1 && !kills(3'(c))) ? 32'(st) : 0);
          chk("R8 supply", 32'(snoop_supply), 0);
        end

    // R9 / R10 / R11 sweep
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 2; v++)
        for (int h = 0; h < 2; h++) begin
          req_cmd = 3'(c); fill_orig_cmd = 3'(c); req_valid = v[0]; req_hit = h[0];
          #1;
          chk("R9 bus_cmd", 32'(bus_cmd), (c == 5) ? 5 : 0);
          chk("R10 fill_state", 32'(fill_state), (c == 6) ? 32'hB : 32'h3);
          chk("R11 warn", 32'(pf_hit_warn), (v == 1 && h == 1 && c == 6) ? 1 : 0);
        end
    req_valid = 0;

    // R2: every code, hit and miss, non-top level
    for (int c = 0; c < 8; c++) begin
      snoop_hit = c[0];
      snoop(3'(c), 32'h1000_0000 + 32'(c) * 64, 8'(16 + c));
    end
    chk("R5 coh_req set", 32'(coh_req), 1);
    // R3: top level stores nothing
    top_level = 1;
    for (int c = 0; c < 8; c++) snoop(3'(c), 32'h2000_0000 + 32'(c), 8'h40);
    top_level = 0;
    chk("R2 count", 32'(model.size()), 4);
    while (model.size() > 0) take_one();
    chk("R3 nothing more", 32'(fwd_valid), 0);
    chk("R5 coh_req clear", 32'(coh_req), 0);

    // R4: ready while empty has no effect
    fwd_ready = 1; tick(); fwd_ready = 0;
    chk("R4 empty ready", 32'(fwd_valid), 0);
    snoop(3'd3, 32'hABCD_0000, 8'h20);
    take_one();
    chk("R5 coh_req after last", 32'(coh_req), 0);

    // R6: fill to depth
    for (int i = 0; i < DEPTH; i++) begin
      snoop(3'(1 + (i % 4)), 32'h3000_0000 + 32'(i) * 32, 8'(i));
      if (i == DEPTH - 2) chk("R6 not blocked at DEPTH-1", 32'(snoop_blocked), 0);
    end
    chk("R6 blocked at full", 32'(snoop_blocked), 1);
    snoop(3'd3, 32'hDEAD_0000, 8'hFF);  // dropped (model refuses too)
    chk("R6 still blocked", 32'(snoop_blocked), 1);
    take_one();
    chk("R6 unblocked after take", 32'(snoop_blocked), 0);

    // R7: store and take together at DEPTH-1
    begin
      logic [39:0] e;
      e = model.pop_front();
      chk("R7 head addr", fwd_addr, e[39:8]);
      snoop_valid = 1; snoop_cmd = 3'd4; snoop_addr = 32'h4444_0000; snoop_size = 8'h44;
      fwd_ready = 1;
      model.push_back({32'h4444_0000, 8'h44});
      tick();
      snoop_valid = 0; fwd_ready = 0;
    end
    chk("R7 count kept", 32'(snoop_blocked), 0);
    snoop(3'd2, 32'h5555_0000, 8'h55);
    chk("R7 full again", 32'(snoop_blocked), 1);
    while (model.size() > 0) take_one();
    chk("R6 drained", 32'(fwd_valid), 0);
    chk("R5 drained", 32'(coh_req), 0);
    chk("R6 blocked low", 32'(snoop_blocked), 0);

    summary();
  end
endmodule